// File: doc/BRIEF.md
# SPI Device Interrupt and Sync Responder

This block is the device end of a host link carried over a mode-0 SPI bus. It runs on a fast local clock and oversamples the SPI pins. Received data is assembled into 32-bit words, most significant bit first. The host writes a write-sync word, and every word that follows goes out on a receive stream, with a marker on the first word of each message. When the local side has a message for the host, it pulses a request input. The block then raises an active-high interrupt and holds it.

The host answers the interrupt with a read-sync word. This clears the interrupt, and the block starts its response. While the message source is not yet valid, the block sends all-ones filler. When the source is valid, it sends the device-to-host sync word, then the source words up to and including the one flagged last. If a read sync arrives while no request is pending, the block sends the device-to-host sync word followed by a fixed dummy word, so the host never waits on a silent device.

MISO is provided as a data bit plus an output enable, for an external tri-state buffer. The enable is low whenever chip select is inactive and in the gap between words, so several slaves can share the bus. All sync values are parameters.

Top module: `spi_irq_sync_dev`

## Requirements
- R1: MOSI is sampled on SCLK rising edges while chip select (active low) is asserted, and 32 bits form one word, first bit received = bit 31.
- R2: MISO presents bit 31 of the current transmit word first and changes only after an SCLK falling edge or a chip-select falling edge; the enable rises only at one of those events.
- R3: miso_oe_o is low while chip select is deasserted, and low from the 32nd rising edge of a word until the next falling SCLK edge.
- R4: A one-cycle pulse on msg_req_i raises irq_o, and irq_o stays high until a read sync is received.
- R5: Receiving the read-sync word (parameter SYNC_RD) clears irq_o.
- R6: With a pending request and a valid source, the response is the sync word SYNC_D2H, then the source words in order up to and including the one with msg_last_i set. The block returns to idle after that word.
- R7: While a request is pending and the source is not valid, the word sent is filler 32'hFFFF_FFFF, repeated until the source becomes valid.
- R8: A read sync received with no pending request produces exactly SYNC_D2H followed by DUMMY_WORD.
- R9: MOSI content received during a response has no effect: neither sync decoding nor the receive stream sees it.
- R10: After the write-sync word (SYNC_WR), each further word appears once on rx_data_o with rx_valid_o, and rx_sop_o is set only on the first word. Words received in idle are dropped.
- R11: Transfers work both with chip select held low across words and with chip select toggled around each word.
- R12: msg_ready_o is asserted only while msg_valid_i is high, and one source word is consumed per asserted cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local clock, at least 6x SCLK |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | SPI clock from host, idles low |
| csn_i | input | 1 | Chip select, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| miso_oe_o | output | 1 | Enable for the external MISO driver |
| irq_o | output | 1 | Message pending, active high |
| msg_req_i | input | 1 | Pulse: a message for the host is coming |
| msg_data_i | input | 32 | Outgoing message word |
| msg_last_i | input | 1 | Current source word ends the message |
| msg_valid_i | input | 1 | Source word available |
| msg_ready_o | output | 1 | Source word taken this cycle |
| rx_data_o | output | 32 | Received command word |
| rx_sop_o | output | 1 | First word after a write sync |
| rx_valid_o | output | 1 | rx_data_o holds a new word |

## Verification
The bench pushes a write sync and command words with chip select both held low and toggled per word. A design that miscounted bits at a chip-select edge would show shifted words, and one that lost the start marker would mark the wrong word. It sends write-sync patterns on MOSI during a response. A design that kept decoding there would leave the response early or put phantom words on the receive stream. It holds the source invalid for three words to require exactly three fillers, and it issues a read sync with nothing pending to require the dummy pair rather than silence. MISO enable is sampled inside every word and in the inter-word gap, which catches a driver that holds the bus between words.

// File: rtl/spi_irq_sync_pkg.sv
package spi_irq_sync_pkg;
  localparam int WORD_W = 32;
  localparam int BIT_W  = $clog2(WORD_W);
  typedef logic [WORD_W-1:0] word_t;
  localparam word_t FILL_WORD = '1;
  typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_READ} link_st_e;
  typedef enum logic [1:0] {RP_WAIT, RP_BODY, RP_END} rsp_ph_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int N = 3,
  parameter int STAGES = 2,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] sr [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) sr[s] <= RST_VAL;
    end else begin
      sr[0] <= d_i;
      for (int s = 1; s < STAGES; s++) sr[s] <= sr[s-1];
    end
  end

  assign q_o = sr[STAGES-1];
endmodule

// File: rtl/spi_edge_det.sv
module spi_edge_det #(
  parameter bit DETECT_RISE = 1'b1,
  parameter bit RST_LVL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic pulse_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_LVL;
    else         prev_q <= lvl_i;
  end

  generate
    if (DETECT_RISE) begin : g_rise
      assign pulse_o = lvl_i & ~prev_q;
    end else begin : g_fall
      assign pulse_o = ~lvl_i & prev_q;
    end
  endgenerate
endmodule

// File: rtl/spi_word_shifter.sv
module spi_word_shifter import spi_irq_sync_pkg::*; (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  cs_act_i,
  input  logic  sclk_rise_i,
  input  logic  sclk_fall_i,
  input  logic  cs_fall_i,
  input  logic  mosi_i,
  input  word_t load_word_i,
  output word_t rx_word_o,
  output logic  word_done_o,
  output logic  miso_o,
  output logic  miso_oe_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

  logic [BIT_W-1:0] bit_cnt_q, tx_idx_q;
  word_t rx_sh_q, tx_word_q;
  logic  tx_busy_q;

  assign rx_word_o   = {rx_sh_q[WORD_W-2:0], mosi_i};
  assign word_done_o = cs_act_i & sclk_rise_i & (bit_cnt_q == LAST_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_cnt_q <= '0;
      tx_idx_q  <= '0;
      rx_sh_q   <= '0;
      tx_word_q <= FILL_WORD;
      tx_busy_q <= 1'b0;
    end else if (!cs_act_i) begin
      bit_cnt_q <= '0;
      tx_idx_q  <= '0;
      tx_busy_q <= 1'b0;
    end else if (sclk_rise_i) begin
      rx_sh_q   <= rx_word_o;
      bit_cnt_q <= word_done_o ? '0 : bit_cnt_q + 1'b1;
      if (word_done_o) begin
        // next word staged now; bus released until next falling edge
        tx_word_q <= load_word_i;
        tx_idx_q  <= '0;
        tx_busy_q <= 1'b0;
      end
    end else if (sclk_fall_i) begin
      if (tx_busy_q) tx_idx_q <= tx_idx_q + 1'b1;
      else           tx_busy_q <= 1'b1;
    end else if (cs_fall_i) begin
      tx_busy_q <= 1'b1;
    end
  end

  assign miso_o    = tx_word_q[LAST_BIT - tx_idx_q];
  assign miso_oe_o = tx_busy_q;
endmodule

// File: rtl/spi_sync_ctrl.sv
module spi_sync_ctrl import spi_irq_sync_pkg::*; #(
  parameter word_t SYNC_WR    = 32'hA5C3_0F01,
  parameter word_t SYNC_RD    = 32'h5A3C_F002,
  parameter word_t SYNC_D2H   = 32'hC0DE_0003,
  parameter word_t DUMMY_WORD = 32'h0000_DEAD
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  word_done_i,
  input  word_t rx_word_i,
  input  logic  msg_req_i,
  input  word_t msg_data_i,
  input  logic  msg_last_i,
  input  logic  msg_valid_i,
  output word_t load_word_o,
  output logic  msg_ready_o,
  output logic  irq_o,
  output word_t rx_data_o,
  output logic  rx_sop_o,
  output logic  rx_valid_o
);
  link_st_e st_q, st_n;
  rsp_ph_e  ph_q, ph_n;
  logic have_q, have_n, pend_q, sop_pend_q, sop_pend_n;
  logic clr_pend, rx_emit, enter_rd;

  always_comb begin
    st_n = st_q;
    ph_n = ph_q;
    have_n = have_q;
    sop_pend_n = sop_pend_q;
    clr_pend = 1'b0;
    rx_emit = 1'b0;
    enter_rd = 1'b0;
    load_word_o = FILL_WORD;
    msg_ready_o = 1'b0;
    if (word_done_i) begin
      unique case (st_q)
        ST_IDLE, ST_WRITE: begin
          if (rx_word_i == SYNC_RD) begin
            enter_rd = 1'b1;
          end else if (rx_word_i == SYNC_WR) begin
            st_n = ST_WRITE;
            sop_pend_n = 1'b1;
          end else if (st_q == ST_WRITE) begin
            rx_emit = 1'b1;
            sop_pend_n = 1'b0;
          end
        end
        ST_READ: if (ph_q == RP_END) st_n = ST_IDLE;  // MOSI ignored here
        default: st_n = ST_IDLE;
      endcase
      if (enter_rd) begin
        st_n = ST_READ;
        ph_n = RP_WAIT;
        have_n = pend_q;
        clr_pend = 1'b1;
      end
      if (st_n == ST_READ) begin
        unique case (ph_n)
          RP_WAIT: if (!have_n || msg_valid_i) begin
            load_word_o = SYNC_D2H;
            ph_n = RP_BODY;
          end
          RP_BODY: begin
            if (!have_n) begin
              load_word_o = DUMMY_WORD;
              ph_n = RP_END;
            end else if (msg_valid_i) begin
              load_word_o = msg_data_i;
              msg_ready_o = 1'b1;
              if (msg_last_i) ph_n = RP_END;
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;
      ph_q <= RP_WAIT;
      have_q <= 1'b0;
      pend_q <= 1'b0;
      sop_pend_q <= 1'b0;
      rx_data_o <= '0;
      rx_sop_o <= 1'b0;
      rx_valid_o <= 1'b0;
    end else begin
      st_q <= st_n;
      ph_q <= ph_n;
      have_q <= have_n;
      pend_q <= (pend_q & ~clr_pend) | msg_req_i;
      sop_pend_q <= sop_pend_n;
      rx_valid_o <= rx_emit;
      rx_sop_o <= rx_emit & sop_pend_q;
      if (rx_emit) rx_data_o <= rx_word_i;
    end
  end

  assign irq_o = pend_q;
endmodule

// File: rtl/spi_irq_sync_dev.sv
module spi_irq_sync_dev import spi_irq_sync_pkg::*; #(
  parameter word_t SYNC_WR    = 32'hA5C3_0F01,
  parameter word_t SYNC_RD    = 32'h5A3C_F002,
  parameter word_t SYNC_D2H   = 32'hC0DE_0003,
  parameter word_t DUMMY_WORD = 32'h0000_DEAD,
  parameter int    SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        sclk_i,
  input  logic        csn_i,
  input  logic        mosi_i,
  output logic        miso_o,
  output logic        miso_oe_o,
  output logic        irq_o,
  input  logic        msg_req_i,
  input  logic [31:0] msg_data_i,
  input  logic        msg_last_i,
  input  logic        msg_valid_i,
  output logic        msg_ready_o,
  output logic [31:0] rx_data_o,
  output logic        rx_sop_o,
  output logic        rx_valid_o
);
  logic [2:0] pins_q;
  logic sclk_rise, sclk_fall, cs_fall, cs_act, word_done;
  word_t rx_word, load_word;

  spi_pin_sync #(.N(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk_i, .rst_ni, .d_i({mosi_i, csn_i, sclk_i}), .q_o(pins_q)
  );

  spi_edge_det #(.DETECT_RISE(1'b1), .RST_LVL(1'b0)) u_sclk_r (
    .clk_i, .rst_ni, .lvl_i(pins_q[0]), .pulse_o(sclk_rise)
  );
  spi_edge_det #(.DETECT_RISE(1'b0), .RST_LVL(1'b0)) u_sclk_f (
    .clk_i, .rst_ni, .lvl_i(pins_q[0]), .pulse_o(sclk_fall)
  );
  spi_edge_det #(.DETECT_RISE(1'b0), .RST_LVL(1'b1)) u_cs_f (
    .clk_i, .rst_ni, .lvl_i(pins_q[1]), .pulse_o(cs_fall)
  );

  assign cs_act = ~pins_q[1];

  spi_word_shifter u_shift (
    .clk_i, .rst_ni,
    .cs_act_i(cs_act), .sclk_rise_i(sclk_rise), .sclk_fall_i(sclk_fall),
    .cs_fall_i(cs_fall), .mosi_i(pins_q[2]), .load_word_i(load_word),
    .rx_word_o(rx_word), .word_done_o(word_done),
    .miso_o, .miso_oe_o
  );

  spi_sync_ctrl #(
    .SYNC_WR(SYNC_WR), .SYNC_RD(SYNC_RD), .SYNC_D2H(SYNC_D2H), .DUMMY_WORD(DUMMY_WORD)
  ) u_ctrl (
    .clk_i, .rst_ni, .word_done_i(word_done), .rx_word_i(rx_word),
    .msg_req_i, .msg_data_i, .msg_last_i, .msg_valid_i,
    .load_word_o(load_word), .msg_ready_o, .irq_o,
    .rx_data_o, .rx_sop_o, .rx_valid_o
  );
endmodule

// File: rtl/spi_irq_sync_chk.sv
module spi_irq_sync_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic sclk_fall,
  input logic cs_fall,
  input logic word_done,
  input logic miso_oe_o,
  input logic irq_o,
  input logic msg_req_i,
  input logic msg_ready_o,
  input logic msg_valid_i,
  input logic rx_sop_o,
  input logic rx_valid_o
);
  // R3
  cs_off_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_act |=> !miso_oe_o);
  // R3
  word_gap_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_done |=> !miso_oe_o);
  // R2
  drive_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(miso_oe_o) |-> $past(sclk_fall || cs_fall));
  // R4
  irq_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(msg_req_i));
  // R5
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(irq_o) |-> $past(word_done));
  // R12
  ready_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_ready_o |-> msg_valid_i);
  // R10
  sop_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sop_o |-> rx_valid_o);
endmodule

bind spi_irq_sync_dev spi_irq_sync_chk u_chk (.*);

// File: tb/spi_irq_sync_dev_test.sv
module spi_irq_sync_dev_test;
  localparam logic [31:0] S_WR  = 32'hA5C3_0F01;
  localparam logic [31:0] S_RD  = 32'h5A3C_F002;
  localparam logic [31:0] S_D2H = 32'hC0DE_0003;
  localparam logic [31:0] DUMMY = 32'h0000_DEAD;
  localparam logic [31:0] FILL  = 32'hFFFF_FFFF;
  localparam int HALF = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sclk = 1'b0, csn = 1'b1, mosi = 1'b0, msg_req = 1'b0;
  logic [31:0] msg_data = '0;
  logic msg_last = 1'b0, msg_valid = 1'b0;
  logic miso, miso_oe, irq, msg_ready, rx_sop, rx_valid;
  logic [31:0] rx_data;

  int n_checks = 0, n_err = 0, n_rx = 0;
  bit done = 1'b0, src_en = 1'b0;
  logic [32:0] rx_exp_q[$];
  logic [32:0] src_q[$];

  always #4 clk = ~clk;

  spi_irq_sync_dev #(.SYNC_WR(S_WR), .SYNC_RD(S_RD), .SYNC_D2H(S_D2H), .DUMMY_WORD(DUMMY)) uut (
    .clk_i(clk), .rst_ni, .sclk_i(sclk), .csn_i(csn), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .irq_o(irq), .msg_req_i(msg_req),
    .msg_data_i(msg_data), .msg_last_i(msg_last), .msg_valid_i(msg_valid),
    .msg_ready_o(msg_ready), .rx_data_o(rx_data), .rx_sop_o(rx_sop), .rx_valid_o(rx_valid)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  // host word transfer, mode 0, MSB first
  task automatic xfer(input logic [31:0] tx, output logic [31:0] rx,
                      output logic oe_in, output logic oe_gap);
    oe_in = 1'b1;
    for (int i = 31; i >= 0; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      oe_in &= miso_oe;
      rx[i] = miso;
      sclk = 1'b1;
      wait_clk(HALF);
      if (i == 0) oe_gap = miso_oe;
      sclk = 1'b0;
    end
  endtask

  task automatic cs_lo(); csn = 1'b0; wait_clk(HALF); endtask
  task automatic cs_hi(); wait_clk(HALF); csn = 1'b1; wait_clk(2*HALF); endtask

  // transfer with drive checks, expected read word
  task automatic xfer_chk(string tag, logic [31:0] tx, logic [31:0] exp);
    logic [31:0] rx;
    logic oi, og;
    xfer(tx, rx, oi, og);
    chk(tag, rx, exp);
    chk("R2 miso enabled through word", {31'b0, oi}, 32'd1);
    chk("R3 miso released in gap", {31'b0, og}, 32'd0);
  endtask

  task automatic push_rx(logic sop, logic [31:0] d);
    rx_exp_q.push_back({sop, d});
  endtask

  task automatic req_pulse();
    msg_req = 1'b1;
    wait_clk(1);
    msg_req = 1'b0;
    wait_clk(3);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rst_ni && rx_valid) begin
        logic [32:0] e;
        n_rx++;
        if (rx_exp_q.size() == 0) begin
          n_checks++;
          n_err++;
          $display("FAIL R10/R9 unexpected rx actual=%h expected=none", rx_data);
        end else begin
          e = rx_exp_q.pop_front();
          chk("R10 rx data", rx_data, e[31:0]);
          chk("R10 rx sop", {31'b0, rx_sop}, {31'b0, e[32]});
        end
      end
    end
  end

  // message source model
  initial begin
    forever begin
      logic hs;
      @(negedge clk);
      hs = msg_valid && msg_ready;
      @(posedge clk);
      #1;
      if (hs) void'(src_q.pop_front());
      msg_valid = src_en && (src_q.size() > 0);
      if (src_q.size() > 0) {msg_last, msg_data} = src_q[0];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] rx;
    logic oi, og;
    int fills;
    bit found;
    wait_clk(5);
    rst_ni = 1'b1;
    wait_clk(2);
    chk("reset irq", {31'b0, irq}, 32'd0);
    chk("reset R3 oe", {31'b0, miso_oe}, 32'd0);
    chk("reset rx_valid", {31'b0, rx_valid}, 32'd0);
    chk("reset ready", {31'b0, msg_ready}, 32'd0);

    // R1 R10 R11: write message, chip select held
    cs_lo();
    xfer_chk("R7 idle filler", S_WR, FILL);
    push_rx(1'b1, 32'h8000_0001); xfer_chk("R7 filler", 32'h8000_0001, FILL);
    push_rx(1'b0, 32'h1234_5678); xfer_chk("R7 filler", 32'h1234_5678, FILL);
    push_rx(1'b0, 32'h0F0F_A5A5); xfer_chk("R7 filler", 32'h0F0F_A5A5, FILL);
    cs_hi();
    // R11: chip select toggled per word, new write sync restarts sop
    cs_lo(); xfer(S_WR, rx, oi, og); cs_hi();
    push_rx(1'b1, 32'hDEAD_BEEF); cs_lo(); xfer(32'hDEAD_BEEF, rx, oi, og); cs_hi();
    push_rx(1'b0, 32'h0000_0002); cs_lo(); xfer(32'h0000_0002, rx, oi, og); cs_hi();
    chk("R3 oe low with cs high", {31'b0, miso_oe}, 32'd0);
    chk("R10 all rx delivered", rx_exp_q.size(), 0);

    // R4 R5 R6 R9 R12: pending message, source ready
    src_q.push_back({1'b0, 32'h1111_0000});
    src_q.push_back({1'b0, 32'h2222_0001});
    src_q.push_back({1'b1, 32'h3333_0002});
    src_en = 1'b1;
    req_pulse();
    chk("R4 irq raised", {31'b0, irq}, 32'd1);
    wait_clk(40);
    chk("R4 irq held", {31'b0, irq}, 32'd1);
    cs_lo();
    xfer(S_RD, rx, oi, og);
    chk("R5 irq cleared", {31'b0, irq}, 32'd0);
    xfer_chk("R6 sync first", S_WR, S_D2H);
    xfer_chk("R6 body 0", S_WR, 32'h1111_0000);
    xfer_chk("R6 body 1", S_WR, 32'h2222_0001);
    xfer_chk("R6 body last", S_WR, 32'h3333_0002);
    xfer_chk("R9 idle after response", 32'h4444_4444, FILL);
    chk("R9 no rx from response", n_rx, 5);
    chk("R12 source drained", src_q.size(), 0);
    push_rx(1'b1, 32'h5555_0005);
    xfer(S_WR, rx, oi, og);
    xfer(32'h5555_0005, rx, oi, og);
    // R8: read sync with nothing pending
    xfer(S_RD, rx, oi, og);
    xfer_chk("R8 dummy sync", FILL, S_D2H);
    xfer_chk("R8 dummy word", FILL, DUMMY);
    xfer_chk("R8 back to idle", FILL, FILL);
    cs_hi();
    chk("R8 irq stays low", {31'b0, irq}, 32'd0);

    // R7: source late, fillers before sync
    src_en = 1'b0;
    src_q.push_back({1'b0, 32'hAAAA_0000});
    src_q.push_back({1'b1, 32'hBBBB_0001});
    req_pulse();
    cs_lo();
    xfer(S_RD, rx, oi, og);
    fills = 0;
    found = 1'b0;
    for (int k = 0; k < 8 && !found; k++) begin
      xfer(FILL, rx, oi, og);
      if (k == 1) src_en = 1'b1;
      if (rx == S_D2H) found = 1'b1;
      else begin
        fills++;
        chk("R7 filler value", rx, FILL);
      end
    end
    chk("R7 sync found", {31'b0, found}, 32'd1);
    chk("R7 filler count", fills, 3);
    xfer_chk("R6 late body 0", FILL, 32'hAAAA_0000);
    xfer_chk("R6 late body last", FILL, 32'hBBBB_0001);
    cs_hi();
    wait_clk(10);
    chk("R10 scoreboard empty", rx_exp_q.size(), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule